// File: doc/BRIEF.md
# MDIO Frame Controller

This block is the station-management master of an Ethernet MAC. Software packs a whole clause-22 management frame into one 32-bit command word and writes it. The block then produces the serial clock `mdc` and shifts the frame out on a tri-state data line. The line is split into `mdio_o`, `mdio_oe` and `mdio_i`. Each frame starts with 32 preamble ones, followed by the command word sent most significant bit first. For a read, the block releases the line from the turnaround onward. It samples the PHY's 16 data bits and writes them back into the data field of the same command word. An `idle` flag tells software when the frame has finished.

The `mdc` period is the core clock divided by 8, 16, 32 or 64, selected by a 2-bit code. Software should pick the smallest divisor that keeps `mdc` within the PHY's limit:

| Core clock | Divisor |
|---|---|
| 20 MHz or less | /8 |
| 40 MHz or less | /16 |
| 80 MHz or less | /32 |
| Faster | /64 |

Transfers run only while the management enable input is high.

The controller is a five-state machine:

| State | Bits of the frame | Leaves on | Goes to |
|---|---|---|---|
| `ST_IDLE` | None | An accepted command | `ST_PREAMBLE` |
| `ST_PREAMBLE` | Bits 0..31 | End of bit 31 | `ST_HEADER` |
| `ST_HEADER` | Bits 32..45: start, op, PHY address, register address | End of bit 45 | `ST_TURN` |
| `ST_TURN` | Bits 46..47 | End of bit 47 | `ST_DATA` |
| `ST_DATA` | Bits 48..63 | End of bit 63 | `ST_IDLE` |

From any busy state, a low enable aborts the frame and returns the machine to `ST_IDLE`.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, `idle`=1, `mdc`=0, `mdio_oe`=0 and `cmd_rdata`=0.
- R2: The command word fields, from most to least significant bit, are:
  - [31:30] start code
  - [29:28] operation
  - [27:23] PHY address
  - [22:18] register address
  - [17:16] turnaround
  - [15:0] data

  A write (`cmd_wr`) while idle with `mgmt_en`=1 stores the word and starts a frame. From the next cycle, `idle`=0, `mdio_oe`=1 and `mdio_o`=1.
- R3: The frame is 32 ones followed by `cmd_rdata[31]` down to `cmd_rdata[0]`. A driven `mdio_o` changes only on the same clock on which `mdc` falls.
- R4: Each bit lasts D core clocks. `mdc` is low for the first D/2 clocks and high for the last D/2. The divider code maps 00→8, 01→16, 10→32 and 11→64. The code is captured when a frame starts, so a change during the frame has no effect on it.
- R5: An operation field of 10 marks a read. A read drives only frame bits 0..45 and holds `mdio_oe`=0 from bit 46 to the end. Any other operation code drives all 64 bits.
- R6: On a read, `mdio_i` is sampled on the rising `mdc` edge of bits 48..63, most significant bit first. The result replaces `cmd_rdata[15:0]` on the cycle `idle` returns to 1. Bits 31:16 are left unchanged.
- R7: A command write while a frame is running is ignored. Neither `cmd_rdata` nor the frame on the line changes.
- R8: A command write with `mgmt_en`=0 stores the word but starts nothing. If `mgmt_en` falls during a frame, the frame aborts on the next clock: `idle`=1, `mdc`=0, `mdio_oe`=0, and the data field is not updated.
- R9: Whenever `idle`=1, `mdc`=0 and `mdio_oe`=0.
- R10: A completed frame returns `idle` to 1 exactly 64·D clocks after the command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_en | input | 1 | Management port enable |
| mdc_div_sel | input | 2 | Divider code for `mdc` |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Stored command word, with read data once a read completes |
| idle | output | 1 | 1 when no frame is running |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A bit counter that is off by one would first show up as shifted `mdio_o` data or a premature `ST_TURN` release. Because a reference model is compared on every clock, the error is seen on the very next bit boundary, within D clocks. Divider faults change the `mdc` high and low phases inside the first bit. Faults in the capture or write-back path only appear when `idle` rises at the end of a read, so several reads with distinct data patterns are run. Aborts and busy writes are checked on the cycle right after the stimulus.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREAMBLE = 3'd1,
        ST_HEADER   = 3'd2,
        ST_TURN     = 3'd3,
        ST_DATA     = 3'd4
    } mdio_state_e;

    localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_LOG_MIN = 3,
    parameter int CNT_W       = DIV_LOG_MIN + 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       rise_tick,
    output logic       fall_tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             high_q;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    // Half period is 2^(DIV_LOG_MIN-1+sel) clocks.
    always_comb begin
        half_m1 = CNT_W'((1 << (DIV_LOG_MIN - 1 + int'(sel))) - 1);
    end

    assign wrap      = run && (cnt_q == half_m1);
    assign rise_tick = wrap && !high_q;
    assign fall_tick = wrap && high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            high_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            high_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            high_q <= !high_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WIDTH-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_BITS = 32,
    parameter int ADDR_W        = 5,
    parameter int DATA_W        = 16,
    parameter int DIV_LOG_MIN   = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 mgmt_en,
    input  logic [1:0]                           mdc_div_sel,
    input  logic                                 cmd_wr,
    input  logic [4+2*ADDR_W+2+DATA_W-1:0]       cmd_wdata,
    output logic [4+2*ADDR_W+2+DATA_W-1:0]       cmd_rdata,
    output logic                                 idle,
    output logic                                 mdc,
    output logic                                 mdio_o,
    output logic                                 mdio_oe,
    input  logic                                 mdio_i
);
    localparam int HDR_BITS   = 4 + 2 * ADDR_W;
    localparam int TA_BITS    = 2;
    localparam int CMD_W      = HDR_BITS + TA_BITS + DATA_W;
    localparam int FRAME_BITS = PREAMBLE_BITS + CMD_W;
    localparam int BIT_W      = $clog2(FRAME_BITS + 1);
    localparam int CMD_IDX_W  = $clog2(CMD_W);
    localparam int CNT_W      = DIV_LOG_MIN + 2;
    localparam int OP_HI      = CMD_W - 3;
    localparam int OP_LO      = CMD_W - 4;
    localparam int RELEASE_AT = PREAMBLE_BITS + HDR_BITS;

    localparam logic [BIT_W-1:0] PRE_LAST  = BIT_W'(PREAMBLE_BITS - 1);
    localparam logic [BIT_W-1:0] HDR_LAST  = BIT_W'(PREAMBLE_BITS + HDR_BITS - 1);
    localparam logic [BIT_W-1:0] TA_LAST   = BIT_W'(PREAMBLE_BITS + HDR_BITS + TA_BITS - 1);
    localparam logic [BIT_W-1:0] LAST_IDX  = BIT_W'(FRAME_BITS - 1);

    mdio_state_e          state_q, state_d;
    logic [BIT_W-1:0]     bit_idx_q;
    logic [1:0]           div_sel_q;
    logic [CMD_W-1:0]     cmd_q;
    logic                 mdc_q, mdio_o_q, mdio_oe_q;
    logic                 accept, busy, is_read;
    logic                 rise_tick, fall_tick;
    logic                 rx_shift;
    logic [DATA_W-1:0]    rx_word;
    int                   nxt_idx;
    logic                 nxt_val, nxt_drive;

    assign busy    = (state_q != ST_IDLE);
    assign accept  = !busy && cmd_wr && mgmt_en;
    assign is_read = (cmd_q[OP_HI:OP_LO] == OP_READ);

    mdio_mdc_gen #(
        .DIV_LOG_MIN (DIV_LOG_MIN),
        .CNT_W       (CNT_W)
    ) u_mdc_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .sel       (div_sel_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    assign rx_shift = rise_tick && (state_q == ST_DATA) && is_read;

    mdio_rx_capture #(
        .WIDTH (DATA_W)
    ) u_rx_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .shift_en (rx_shift),
        .din      (mdio_i),
        .word     (rx_word)
    );

    // Next state: advance at the end of the last bit of each section.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_tick && bit_idx_q == PRE_LAST) state_d = ST_HEADER;
            ST_HEADER:   if (fall_tick && bit_idx_q == HDR_LAST) state_d = ST_TURN;
            ST_TURN:     if (fall_tick && bit_idx_q == TA_LAST)  state_d = ST_DATA;
            ST_DATA:     if (fall_tick && bit_idx_q == LAST_IDX) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (busy && !mgmt_en) state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit position within the frame and divider capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            div_sel_q <= 2'b00;
        end else if (accept) begin
            bit_idx_q <= '0;
            div_sel_q <= mdc_div_sel;
        end else if (busy && fall_tick) begin
            bit_idx_q <= bit_idx_q + 1'b1;
        end
    end

    // Value and drive of the bit that follows the current one.
    always_comb begin
        nxt_idx = int'(bit_idx_q) + 1;
        if (nxt_idx < PREAMBLE_BITS)
            nxt_val = 1'b1;
        else if (nxt_idx < FRAME_BITS)
            nxt_val = cmd_q[CMD_IDX_W'(CMD_W - 1 - (nxt_idx - PREAMBLE_BITS))];
        else
            nxt_val = 1'b0;
        nxt_drive = !is_read || (nxt_idx < RELEASE_AT);
    end

    // Output and command register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q     <= 1'b0;
            mdio_o_q  <= 1'b0;
            mdio_oe_q <= 1'b0;
            cmd_q     <= '0;
        end else if (!busy) begin
            mdc_q     <= 1'b0;
            mdio_oe_q <= accept;
            mdio_o_q  <= accept;
            if (cmd_wr) cmd_q <= cmd_wdata;
        end else if (!mgmt_en) begin
            mdc_q     <= 1'b0;
            mdio_oe_q <= 1'b0;
            mdio_o_q  <= 1'b0;
        end else begin
            if (rise_tick) mdc_q <= 1'b1;
            if (fall_tick) begin
                mdc_q <= 1'b0;
                if (bit_idx_q == LAST_IDX) begin
                    mdio_oe_q <= 1'b0;
                    mdio_o_q  <= 1'b0;
                    if (is_read) cmd_q[DATA_W-1:0] <= rx_word;
                end else begin
                    mdio_oe_q <= nxt_drive;
                    mdio_o_q  <= nxt_drive && nxt_val;
                end
            end
        end
    end

    assign cmd_rdata = cmd_q;
    assign idle      = !busy;
    assign mdc       = mdc_q;
    assign mdio_o    = mdio_o_q;
    assign mdio_oe   = mdio_oe_q;
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk #(
    parameter int CMD_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mgmt_en,
    input logic             cmd_wr,
    input logic [CMD_W-1:0] cmd_rdata,
    input logic             idle,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_wr && mgmt_en) |=> (!idle && mdio_oe && mdio_o));

    assert_change_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cmd_wr) |=> (cmd_rdata[CMD_W-1:16] == $past(cmd_rdata[CMD_W-1:16])));

    assert_disable_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> idle);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(.CMD_W(CMD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mgmt_en   (mgmt_en),
    .cmd_wr    (cmd_wr),
    .cmd_rdata (cmd_rdata),
    .idle      (idle),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_frame_ctrl_tb.sv
module mdio_frame_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_en = 1'b0;
    logic [1:0]  mdc_div_sel = 2'b00;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = !clk;

    mdio_frame_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .mgmt_en (mgmt_en), .mdc_div_sel (mdc_div_sel),
        .cmd_wr (cmd_wr), .cmd_wdata (cmd_wdata), .cmd_rdata (cmd_rdata),
        .idle (idle), .mdc (mdc), .mdio_o (mdio_o), .mdio_oe (mdio_oe), .mdio_i (mdio_i)
    );

    // Behavioural reference: elapsed clocks since acceptance decide every output.
    bit          m_busy = 0;
    bit          m_read = 0;
    int          m_t = 0;
    int          m_div = 8;
    logic [31:0] m_reg = '0;
    logic [63:0] m_frame = '0;
    logic [15:0] phy_data = 16'h0000;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_reg <= '0; m_t <= 0;
        end else if (m_busy) begin
            if (!mgmt_en) m_busy <= 0;
            else if (m_t + 1 == 64 * m_div) begin
                m_busy <= 0;
                if (m_read) m_reg[15:0] <= phy_data;
            end else m_t <= m_t + 1;
        end else if (cmd_wr) begin
            m_reg <= cmd_wdata;
            if (mgmt_en) begin
                m_busy  <= 1;
                m_t     <= 0;
                m_div   <= 8 << mdc_div_sel;
                m_read  <= (cmd_wdata[29:28] == 2'b10);
                m_frame <= {32'hFFFF_FFFF, cmd_wdata};
            end
        end
    end

    // PHY side: pull-up, zero on second turnaround bit, then the data MSB first.
    always_comb begin
        int b;
        b = m_busy ? (m_t / m_div) : 0;
        if (m_busy && m_read && b >= 48) mdio_i = phy_data[63 - b];
        else if (m_busy && m_read && b == 47) mdio_i = 1'b0;
        else mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!m_busy) begin
                chk("R10 idle", 32'(idle), 32'd1);
                chk("R9 mdc low when idle", 32'(mdc), 32'd0);
                chk("R9 released when idle", 32'(mdio_oe), 32'd0);
            end else begin
                int b, w;
                logic eoe;
                b = m_t / m_div;
                w = m_t % m_div;
                eoe = !m_read || (b < 46);
                chk("R2 busy", 32'(idle), 32'd0);
                chk("R4 mdc phase", 32'(mdc), 32'(w >= m_div / 2));
                chk("R5 drive enable", 32'(mdio_oe), 32'(eoe));
                if (eoe) chk("R3 frame bit", 32'(mdio_o), 32'(m_frame[63 - b]));
            end
            chk("R6 command word", cmd_rdata, m_reg);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    initial begin
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 idle", 32'(idle), 32'd1);
        chk("R1 mdc", 32'(mdc), 32'd0);
        chk("R1 oe", 32'(mdio_oe), 32'd0);
        chk("R1 word", cmd_rdata, 32'd0);
        rst_n = 1'b1;
        mgmt_en = 1'b1;

        // R2/R3/R10: write frame, divide by 8
        mdc_div_sel = 2'b00;
        send(mk(2'b01, 5'h03, 5'h11, 16'hBEEF));
        wait_done();

        // R5/R6: read, divide by 16
        phy_data = 16'hA5C3;
        mdc_div_sel = 2'b01;
        send(mk(2'b10, 5'h1F, 5'h00, 16'h0000));
        wait_done();
        chk("R6 read data", 32'(cmd_rdata[15:0]), 32'h0000A5C3);

        // R4/R7: divide by 32, change code and write again mid-frame
        mdc_div_sel = 2'b10;
        send(mk(2'b01, 5'h0A, 5'h15, 16'h1234));
        keep = cmd_rdata;
        repeat (100) @(negedge clk);
        mdc_div_sel = 2'b11;
        send(32'h5555_AAAA);
        chk("R7 busy write ignored", cmd_rdata, keep);
        wait_done();
        chk("R7 word after frame", cmd_rdata, keep);

        // R6: read at divide by 64, alternate pattern
        phy_data = 16'h3C96;
        send(mk(2'b10, 5'h01, 5'h1E, 16'hFFFF));
        wait_done();
        chk("R6 read data 2", cmd_rdata, {mk(2'b10, 5'h01, 5'h1E, 16'h0)} | 32'h3C96);

        // R8: write while disabled loads but does not start
        mgmt_en = 1'b0;
        send(mk(2'b01, 5'h02, 5'h04, 16'h0F0F));
        repeat (5) @(negedge clk);
        chk("R8 no start when disabled", 32'(idle), 32'd1);
        chk("R8 word loaded", cmd_rdata, mk(2'b01, 5'h02, 5'h04, 16'h0F0F));

        // R8: abort mid-read, data field unchanged
        mgmt_en = 1'b1;
        mdc_div_sel = 2'b00;
        phy_data = 16'h7777;
        send(mk(2'b10, 5'h05, 5'h06, 16'h4242));
        repeat (420) @(negedge clk);
        mgmt_en = 1'b0;
        @(negedge clk);
        chk("R8 abort idle", 32'(idle), 32'd1);
        chk("R8 abort mdc", 32'(mdc), 32'd0);
        chk("R8 abort data kept", 32'(cmd_rdata[15:0]), 32'h4242);

        // Back-to-back frames right after completion
        mgmt_en = 1'b1;
        phy_data = 16'h8001;
        send(mk(2'b10, 5'h07, 5'h08, 16'h0));
        wait_done();
        send(mk(2'b00, 5'h09, 5'h0A, 16'hC001));
        wait_done();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule